// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is a single up-counting timer channel that generates two waveforms, `out_a` and `out_b`, which share one period. The counter advances on prescaled ticks and returns to zero when it reaches the third compare value (C), so C sets the common period. Output A reacts to its own compare value (A) and to C. Output B reacts to its own compare value (B) and to C. A command write can fire a software trigger. The trigger restarts the count and forces each output to a programmed level, and it does this even while the clock is stopped. This lets software park an output at a fixed level.

Software programs the block through a plain synchronous register port. A write strobe with address and data updates a register on the clock edge. A read strobe with address returns the value on `rd_data` one cycle later. An action code is held in the mode word for every event an output reacts to. The code chooses none, set, clear or toggle, so one pair of compare values can give normal PWM, inverted PWM, toggling, or a constant level. The counter width is the parameter `CW`, which must be at least 16. Both 16- and 32-bit builds are intended.

Top module: `dual_cmp_wavegen`

## Requirements
- R1: After reset both outputs are low, the clock is stopped, the mode word and the three compare registers read 0, and the count reads 0.
- R2: A write with `wr_en` updates the register at `wr_addr` on that clock edge. The addresses are 0 = mode, 1 = compare A, 2 = compare B, 3 = compare C, 4 = command. A read with `rd_en` presents the value one cycle later. Reads use addresses 0 to 3 for the registers, 4 for the run flag in bit 0, and 5 for the current count.
- R3: Mode word layout: bits [2:0] clock select, bit 3 unused, [5:4] A action on compare A, [7:6] A action on compare C, [9:8] A action on software trigger, [11:10] B action on compare B, [13:12] B action on compare C, [15:14] B action on software trigger. Action codes are 0 = none, 1 = set, 2 = clear, 3 = toggle.
- R4: Clock select values 0, 1, 2 and 3 give one count tick every 2, 8, 32 and 128 clock cycles. Values 4 to 7 give one tick for each clock cycle in which `slow_tick` is high. No ticks occur while the clock is stopped.
- R5: On each tick the counter increments. If the count equals compare C, it returns to 0 instead.
- R6: On a tick where the count equals compare A (or B), output A (or B) takes its own compare action. On a tick where the count equals compare C, each output takes its compare-C action. The output changes on the clock edge that ends the tick cycle.
- R7: When an output's own compare and compare C match on the same tick, the compare-C action wins if it is not none. Otherwise the own-compare action applies.
- R8: A command write with bit 2 set is a software trigger. It zeroes the count and the prescaler, and each output takes its trigger action at that edge. It overrides any compare event in the same cycle, and it works while the clock is stopped.
- R9: In a command write, bit 0 starts the clock and bit 1 stops it, and stop wins when both are set. While stopped, the count and both outputs hold.
- R10: With no compare-C action and no own-compare action programmed, an output keeps the level from the last software trigger indefinitely.
- R11: A compare register written while counting is used from the next tick after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | CW | Read data, valid the cycle after `rd_en` |
| slow_tick | input | 1 | Slow time-base tick used by clock select 4 to 7 |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
Two pairs of functions can land in the same cycle. A software-trigger command can coincide with a prescaled tick that carries a compare match. Compare A can also equal compare C, so both match on the same tick. The bench provokes the first pair by repeatedly issuing triggers in the fastest divider while the counter runs. It provokes the second by programming A equal to C with conflicting actions, and random runs add more of both. Every cycle is judged against a bench model that applies the priority order software trigger, then compare C when programmed, then own compare.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int MODE_W  = 16;
  localparam int CSEL_W  = 3;
  localparam int ADDR_W  = 3;
  localparam int NCMP    = 3;
  localparam int NOUT    = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPC = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd5;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef struct packed {
    act_e              b_trig;
    act_e              b_cmpc;
    act_e              b_own;
    act_e              a_trig;
    act_e              a_cmpc;
    act_e              a_own;
    logic              spare;
    logic [CSEL_W-1:0] csel;
  } mode_t;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/wt_prescale.sv
module wt_prescale import wt_pkg::*; #(
  parameter int NDIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CSEL_W-1:0] sel,
  input  logic              slow_tick,
  output logic              tick
);
  localparam int PW = 2 * NDIV - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;
  logic          use_slow;

  assign use_slow = int'(sel) >= NDIV;

  always_comb begin
    lim = '0;
    for (int k = 0; k < NDIV; k++) begin
      if (int'(sel) == k) lim = PW'((1 << (1 + 2 * k)) - 1);
    end
  end

  assign tick = run && (use_slow ? slow_tick : (pre_q == lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || restart) begin
      pre_q <= '0;
    end else if (!use_slow) begin
      pre_q <= (pre_q == lim) ? '0 : pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/wt_count.sv
module wt_count import wt_pkg::*; #(
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      restart,
  input  logic [NCMP-1:0][CW-1:0]   cmp,
  output logic [CW-1:0]             cnt,
  output logic [NCMP-1:0]           hit
);
  localparam int IDX_C = NCMP - 1;

  logic [CW-1:0] cnt_q;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = tick && !restart && (cnt_q == cmp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= hit[IDX_C] ? '0 : cnt_q + CW'(1);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wt_outcell.sv
module wt_outcell import wt_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic hit_own,
  input  logic hit_c,
  input  act_e act_own,
  input  act_e act_c,
  input  act_e act_trig,
  output logic q
);
  logic q_r;
  logic q_nx;

  always_comb begin
    if (trig)                            q_nx = apply_act(act_trig, q_r);
    else if (hit_c && act_c != ACT_NONE) q_nx = apply_act(act_c, q_r);
    else if (hit_own)                    q_nx = apply_act(act_own, q_r);
    else                                 q_nx = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/dual_cmp_wavegen.sv
module dual_cmp_wavegen import wt_pkg::*; #(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic              slow_tick,
  output logic              out_a,
  output logic              out_b
);
  localparam int IDX_C = NCMP - 1;

  mode_t                   mode_q;
  logic [NCMP-1:0][CW-1:0] cmp_q;
  logic                    run_q;
  logic                    cmd_wr;
  logic                    sw_fire;
  logic                    tick;
  logic [CW-1:0]           cnt;
  logic [NCMP-1:0]         hit;
  logic [NOUT-1:0]         outs;
  act_e                    own_act  [NOUT];
  act_e                    c_act    [NOUT];
  act_e                    trig_act [NOUT];

  assign cmd_wr  = wr_en && (wr_addr == ADDR_CMD);
  assign sw_fire = cmd_wr && wr_data[CMD_TRIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmp_q  <= '0;
      run_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_MODE: mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        ADDR_CMPA: cmp_q[0] <= wr_data;
        ADDR_CMPB: cmp_q[1] <= wr_data;
        ADDR_CMPC: cmp_q[2] <= wr_data;
        ADDR_CMD: begin
          if (wr_data[CMD_STOP])       run_q <= 1'b0;
          else if (wr_data[CMD_START]) run_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        ADDR_MODE: rd_data <= CW'(mode_q);
        ADDR_CMPA: rd_data <= cmp_q[0];
        ADDR_CMPB: rd_data <= cmp_q[1];
        ADDR_CMPC: rd_data <= cmp_q[2];
        ADDR_CMD:  rd_data <= CW'(run_q);
        ADDR_CNT:  rd_data <= cnt;
        default:   rd_data <= '0;
      endcase
    end
  end

  wt_prescale #(.NDIV(4)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .restart   (sw_fire),
    .sel       (mode_q.csel),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  wt_count #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (sw_fire),
    .cmp     (cmp_q),
    .cnt     (cnt),
    .hit     (hit)
  );

  assign own_act[0]  = mode_q.a_own;
  assign c_act[0]    = mode_q.a_cmpc;
  assign trig_act[0] = mode_q.a_trig;
  assign own_act[1]  = mode_q.b_own;
  assign c_act[1]    = mode_q.b_cmpc;
  assign trig_act[1] = mode_q.b_trig;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    wt_outcell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (sw_fire),
      .hit_own  (hit[o]),
      .hit_c    (hit[IDX_C]),
      .act_own  (own_act[o]),
      .act_c    (c_act[o]),
      .act_trig (trig_act[o]),
      .q        (outs[o])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];
endmodule

// File: rtl/dual_cmp_wavegen_chk.sv
module dual_cmp_wavegen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_fire,
  input logic          run_q,
  input logic          tick,
  input logic          hit_c,
  input logic [CW-1:0] cnt,
  input logic [15:0]   mode,
  input logic          out_a,
  input logic          out_b
);
  // R5: compare C match returns the count to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_c |=> (cnt == '0));

  // R5: an ordinary tick steps the count by one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_fire && !hit_c) |=> (cnt == $past(cnt) + 1'b1));

  // R8: trigger with set action on A drives A high
  p_trig_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fire && mode[9:8] == 2'b01) |=> out_a);

  // R8: trigger with clear action on B drives B low
  p_trig_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fire && mode[15:14] == 2'b10) |=> !out_b);

  // R8: trigger zeroes the count
  p_trig_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> (cnt == '0));

  // R9: stopped clock freezes count and outputs
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !sw_fire) |=> ($stable(cnt) && $stable(out_a) && $stable(out_b)));
endmodule

bind dual_cmp_wavegen dual_cmp_wavegen_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_fire (sw_fire),
  .run_q   (run_q),
  .tick    (tick),
  .hit_c   (hit[2]),
  .cnt     (cnt),
  .mode    (mode_q),
  .out_a   (out_a),
  .out_b   (out_b)
);

// File: tb/dual_cmp_wavegen_bench.sv
module dual_cmp_wavegen_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          slow_tick = 1'b0;
  logic          out_a, out_b;

  always #10 clk = ~clk;

  dual_cmp_wavegen #(.CW(CW)) u_dual_cmp_wavegen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .slow_tick(slow_tick), .out_a(out_a), .out_b(out_b)
  );

  int    nchk = 0;
  int    nerr = 0;
  bit    done = 1'b0;
  string tag = "R1";

  logic [15:0] m_mode = '0;
  logic [15:0] m_cmp [3] = '{default: '0};
  logic        m_en = 1'b0, m_a = 1'b0, m_b = 1'b0;
  logic [15:0] m_cnt = '0;
  logic [6:0]  m_pre = '0;
  logic [15:0] m_rd = '0;
  logic        m_rd_chk = 1'b0;

  function automatic logic act(input logic [1:0] c, input logic cur);
    case (c)
      2'd1: act = 1'b1;
      2'd2: act = 1'b0;
      2'd3: act = ~cur;
      default: act = cur;
    endcase
  endfunction

  function automatic logic [15:0] mk(input int csel, input int aown, input int ac,
                                     input int asw, input int bown, input int bc, input int bsw);
    mk = {bsw[1:0], bc[1:0], bown[1:0], asw[1:0], ac[1:0], aown[1:0], 1'b0, csel[2:0]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] actv, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actv, expv);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] wa, input logic [15:0] wd,
                     input logic re, input logic [2:0] ra, input logic st);
    logic [6:0]  lim;
    logic        tk, sw, hc, ha, hb;
    @(negedge clk);
    chk(out_a === m_a, "out_a", 32'(out_a), 32'(m_a));
    chk(out_b === m_b, "out_b", 32'(out_b), 32'(m_b));
    if (m_rd_chk) chk(rd_data === m_rd, "rd_data", 32'(rd_data), 32'(m_rd));
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; slow_tick = st;
    lim = 7'((1 << (1 + 2 * int'(m_mode[2:0] & 3'd3))) - 1);
    tk  = m_en && ((m_mode[2:0] >= 3'd4) ? st : (m_pre == lim));
    sw  = we && wa == 3'd4 && wd[2];
    hc  = tk && !sw && m_cnt == m_cmp[2];
    ha  = tk && !sw && m_cnt == m_cmp[0];
    hb  = tk && !sw && m_cnt == m_cmp[1];
    m_rd_chk = re;
    if (re) begin
      case (ra)
        3'd0: m_rd = m_mode;
        3'd1: m_rd = m_cmp[0];
        3'd2: m_rd = m_cmp[1];
        3'd3: m_rd = m_cmp[2];
        3'd4: m_rd = 16'(m_en);
        3'd5: m_rd = m_cnt;
        default: m_rd = '0;
      endcase
    end
    if (sw) m_a = act(m_mode[9:8], m_a);
    else if (hc && m_mode[7:6] != 2'd0) m_a = act(m_mode[7:6], m_a);
    else if (ha) m_a = act(m_mode[5:4], m_a);
    if (sw) m_b = act(m_mode[15:14], m_b);
    else if (hc && m_mode[13:12] != 2'd0) m_b = act(m_mode[13:12], m_b);
    else if (hb) m_b = act(m_mode[11:10], m_b);
    if (!m_en || sw) m_pre = '0;
    else if (m_mode[2:0] < 3'd4) m_pre = (m_pre == lim) ? '0 : m_pre + 7'd1;
    if (sw) m_cnt = '0;
    else if (tk) m_cnt = hc ? '0 : m_cnt + 16'd1;
    if (we) begin
      case (wa)
        3'd0: m_mode = wd;
        3'd1: m_cmp[0] = wd;
        3'd2: m_cmp[1] = wd;
        3'd3: m_cmp[2] = wd;
        3'd4: if (wd[1]) m_en = 1'b0; else if (wd[0]) m_en = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic rd(input logic [2:0] a);
    cyc(1'b0, 3'd0, 16'd0, 1'b1, a, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    tag = "R1";
    rd(3'd0); rd(3'd5); rd(3'd4); rd(3'd3); idle(2);

    tag = "R2";
    wr(3'd1, 16'h1234); wr(3'd2, 16'hbeef); wr(3'd3, 16'h00ff);
    rd(3'd1); rd(3'd2); rd(3'd3); idle(1);

    // R5 R6: normal PWM on A, inverted on B, divide by 2
    tag = "R6";
    wr(3'd0, mk(0, 2, 1, 1, 1, 2, 2));
    wr(3'd1, 16'd3); wr(3'd2, 16'd5); wr(3'd3, 16'd9);
    wr(3'd4, 16'h5);
    idle(120);
    tag = "R5"; rd(3'd5); idle(7); rd(3'd5); idle(3);

    // R4: divide by 8 and 128
    tag = "R4";
    wr(3'd0, mk(1, 3, 0, 2, 3, 0, 1)); wr(3'd4, 16'h5); idle(200);
    wr(3'd0, mk(3, 3, 0, 2, 3, 0, 1)); wr(3'd3, 16'd2); wr(3'd4, 16'h5); idle(900);
    // R4: slow tick time base
    wr(3'd0, mk(4, 2, 1, 1, 3, 0, 2)); wr(3'd1, 16'd1); wr(3'd3, 16'd4); wr(3'd4, 16'h5);
    for (int i = 0; i < 150; i++) cyc(1'b0, 3'd0, 16'd0, (i % 9) == 0, 3'd5, (i % 5) == 2);

    // R7: compare A equals compare C
    tag = "R7";
    wr(3'd0, mk(0, 3, 2, 1, 3, 0, 1));
    wr(3'd1, 16'd4); wr(3'd2, 16'd4); wr(3'd3, 16'd4); wr(3'd4, 16'h5);
    idle(80);

    // R8: trigger colliding with running ticks
    tag = "R8";
    wr(3'd0, mk(0, 2, 1, 3, 3, 0, 1)); wr(3'd1, 16'd2); wr(3'd3, 16'd6); wr(3'd4, 16'h5);
    for (int i = 0; i < 12; i++) begin idle(3 + i); wr(3'd4, 16'h4); end
    idle(10);

    // R9: stop freezes; start and stop together means stopped
    tag = "R9";
    wr(3'd4, 16'h2); rd(3'd5); idle(40); rd(3'd5); rd(3'd4);
    wr(3'd4, 16'h3); rd(3'd4); idle(30); rd(3'd5);
    tag = "R8";
    wr(3'd4, 16'h4); idle(5); wr(3'd4, 16'h4); idle(5); rd(3'd5); idle(2);

    // R10: no compare actions, level held from trigger
    tag = "R10";
    wr(3'd0, mk(0, 0, 0, 1, 0, 0, 2)); wr(3'd1, 16'd0); wr(3'd3, 16'd3);
    wr(3'd4, 16'h5); idle(100);

    // R11: compare C shrunk while counting
    tag = "R11";
    wr(3'd0, mk(0, 2, 1, 1, 1, 2, 2)); wr(3'd1, 16'd5); wr(3'd2, 16'd7); wr(3'd3, 16'd20);
    wr(3'd4, 16'h5); idle(30); wr(3'd3, 16'd8); idle(60); wr(3'd1, 16'd2); idle(40);

    // R3: random modes, fields and traffic
    tag = "R3";
    void'($urandom(32'd20240611));
    for (int it = 0; it < 30; it++) begin
      logic [15:0] md;
      md = 16'($urandom);
      md[2:0] = 3'($urandom % 5);
      wr(3'd0, md);
      wr(3'd1, 16'($urandom % 12)); wr(3'd2, 16'($urandom % 12));
      wr(3'd3, 16'($urandom % 12)); wr(3'd4, 16'h5);
      for (int c = 0; c < 110; c++) begin
        int p;
        p = $urandom % 24;
        if (p == 0) cyc(1'b1, 3'(1 + $urandom % 3), 16'($urandom % 12), 1'b0, 3'd0, 1'($urandom));
        else if (p == 1) cyc(1'b1, 3'd4, 16'($urandom % 8), 1'b0, 3'd0, 1'($urandom));
        else if (p < 5) cyc(1'b0, 3'd0, 16'd0, 1'b1, 3'($urandom % 6), 1'($urandom));
        else cyc(1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 1'($urandom));
      end
    end
    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog %s: actual=running expected=finished", tag);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule